// File: doc/BRIEF.md
# CD Drive Status Packet Unit

This block sits between a processor-visible register window and the mechanism controller of a CD drive. It handles the fixed ten-byte packets the two sides exchange. On an export strobe it takes the current 16-bit status word, the minute, second and frame words and an extension byte, and lays them into a ten-byte receive area with each word high byte first. It finishes the packet with a 4-bit checksum, clears the upper bits of the drive control register and, when enabled, raises a level-4 interrupt pulse.

On an import strobe it decodes the ten-byte command area, which software fills one byte at a time. The low nibble of command byte 0 selects the action. For a table-of-contents query, command byte 3 selects a sub-code, and the block writes that sub-code into the low byte of its status word. One clock after the strobe the block presents the chosen action code with a single-cycle valid pulse. It does not model the drive's seeking, playing or timing.

Top module: `cdd_pkt_unit`

## Requirements
- R1: After reset, receive bytes 0 to 8 are 0x00 and byte 9 is 0x0F. The control register, the status word and the command area are zero. `act_valid` and `irq4` are low.
- R2: On the clock edge that samples `exp_stb`, the receive area is loaded as follows:
  - The status word goes to bytes 0 and 1, the minute word to bytes 2 and 3, the second word to bytes 4 and 5, and the frame word to bytes 6 and 7, each with its high byte at the lower offset.
  - The extension byte goes to byte 8.
  - Receive byte k appears on `rx_bytes[8k+7:8k]`.
- R3: Receive byte 9 is loaded with 0 in its upper nibble and a checksum in its lower nibble. To form the checksum, sum d + (d >> 8) over the four words, add the extension byte, and invert the low 4 bits of the total.
- R4: On the edge that samples `exp_stb`, the control register keeps only bits 1:0 and clears bits 7:2. If `ctrl_we` is high in the same cycle, the written value is the one masked.
- R5: `irq4` is high for exactly the cycle after an `exp_stb` cycle in which `irq_en` is high, and is low at all other times.
- R6: The low nibble of command byte 0 selects the action code:
  - 0 status, 1 stop, 3 read, 4 seek, 6 pause, 7 resume, 8 fast forward, 9 rewind, A recover, C close tray and D open tray each give the action code equal to that nibble.
  - 5, B, E and F give the default action 0xF.
  - The upper nibble of byte 0 is ignored.
- R7: When the nibble is 2 and command byte 3 is 0 to 5, the action code is 2 and the status low byte becomes byte 3. For any other value of byte 3, the action code is 0 (status request) and the status low byte becomes 0x0F. In both cases the status high byte is kept. No other command alters the status word.
- R8: `act_valid` is high for exactly the one cycle after each `imp_stb` cycle. `act_code` is valid while `act_valid` is high.
- R9: When `exp_stb` and `imp_stb` fall in the same cycle, the packet carries the status word as it was before that import.
- R10: Without `exp_stb`, the receive area does not change.
- R11: A `stat_we` write in the same cycle as a table-of-contents import sets the high byte of the status word, and the import sets the low byte. `cmd_we` with an index of 10 or more has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_we | input | 1 | Load the status word |
| stat_wdata | input | 16 | Status word value |
| min_i | input | 16 | Minute word for export |
| sec_i | input | 16 | Second word for export |
| frm_i | input | 16 | Frame word for export |
| ext_i | input | 8 | Extension byte for export |
| irq_en | input | 1 | Interrupt mask bit for level 4 |
| exp_stb | input | 1 | Export strobe |
| ctrl_we | input | 1 | Control register write |
| ctrl_wdata | input | 8 | Control register write data |
| cmd_we | input | 1 | Command area byte write |
| cmd_idx | input | 4 | Command area byte index |
| cmd_wdata | input | 8 | Command area byte data |
| imp_stb | input | 1 | Import (decode) strobe |
| rx_bytes | output | 80 | Receive area, byte k at bits 8k+7:8k |
| ctrl_q | output | 8 | Control register |
| stat_lo | output | 8 | Status word low byte |
| act_valid | output | 1 | Action code valid pulse |
| act_code | output | 4 | Decoded action code |
| irq4 | output | 1 | Level-4 interrupt request pulse |

## Verification
Export and import can be strobed in the same cycle, and the two interact through the status word: the import may rewrite its low byte while the export is packing it. The bench raises both strobes together, both in directed cases and within random traffic, with a table-of-contents command loaded. It expects the packet to carry the status word from before the import, with the new low byte visible only on `stat_lo` and in the next export. Control writes coinciding with an export, and status writes coinciding with an import, are provoked the same way and judged against the priority rules of R4 and R11.

// File: rtl/cdd_pkt_pkg.sv
package cdd_pkt_pkg;

   typedef enum logic [3:0] {
      ACT_STATUS  = 4'h0,
      ACT_STOP    = 4'h1,
      ACT_TOC     = 4'h2,
      ACT_READ    = 4'h3,
      ACT_SEEK    = 4'h4,
      ACT_PAUSE   = 4'h6,
      ACT_RESUME  = 4'h7,
      ACT_FFWD    = 4'h8,
      ACT_REWIND  = 4'h9,
      ACT_RECOVER = 4'hA,
      ACT_CLOSE   = 4'hC,
      ACT_OPEN    = 4'hD,
      ACT_OTHER   = 4'hF
   } act_e;

   localparam logic [7:0] TOC_BAD_LO = 8'h0F;

endpackage

// File: rtl/cdd_csum.sv
module cdd_csum #(
   parameter int FW  = 16,
   parameter int NF  = 4,
   parameter int EW  = 8,
   parameter int CSW = 4
) (
   input  logic [NF*FW-1:0] fields,
   input  logic [EW-1:0]    ext,
   output logic [CSW-1:0]   csum
);
   localparam int SW = FW + $clog2(NF + 2) + 2;

   logic [SW-1:0] part [NF+1];

   assign part[0] = SW'(ext);

   for (genvar gi = 0; gi < NF; gi++) begin : g_acc
      logic [FW-1:0] fld;
      assign fld         = fields[gi*FW +: FW];
      assign part[gi+1]  = part[gi] + SW'(fld) + SW'(fld >> 8);
   end

   assign csum = ~part[NF][CSW-1:0];

endmodule

// File: rtl/cdd_cmd_decode.sv
module cdd_cmd_decode
   import cdd_pkt_pkg::*;
#(
   parameter int NUM_SUB = 6
) (
   input  logic [7:0] code_byte,
   input  logic [7:0] sub_byte,
   output act_e       act,
   output logic       lo_upd,
   output logic [7:0] lo_val
);
   always_comb begin
      lo_upd = 1'b0;
      lo_val = 8'h00;
      act    = ACT_OTHER;
      case (code_byte[3:0])
         4'h0: act = ACT_STATUS;
         4'h1: act = ACT_STOP;
         4'h2: begin
            lo_upd = 1'b1;
            if (sub_byte < 8'(NUM_SUB)) begin
               act    = ACT_TOC;
               lo_val = sub_byte;
            end else begin
               act    = ACT_STATUS;
               lo_val = TOC_BAD_LO;
            end
         end
         4'h3: act = ACT_READ;
         4'h4: act = ACT_SEEK;
         4'h6: act = ACT_PAUSE;
         4'h7: act = ACT_RESUME;
         4'h8: act = ACT_FFWD;
         4'h9: act = ACT_REWIND;
         4'hA: act = ACT_RECOVER;
         4'hC: act = ACT_CLOSE;
         4'hD: act = ACT_OPEN;
         default: act = ACT_OTHER;
      endcase
   end

endmodule

// File: rtl/cdd_pkt_unit.sv
module cdd_pkt_unit
   import cdd_pkt_pkg::*;
#(
   parameter int FW        = 16,
   parameter int NF        = 4,
   parameter int CSW       = 4,
   parameter int NUM_SUB   = 6,
   parameter int TOC_IDX   = 3,
   parameter int CMD_IDX_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          stat_we,
   input  logic [FW-1:0]                 stat_wdata,
   input  logic [FW-1:0]                 min_i,
   input  logic [FW-1:0]                 sec_i,
   input  logic [FW-1:0]                 frm_i,
   input  logic [7:0]                    ext_i,
   input  logic                          irq_en,
   input  logic                          exp_stb,
   input  logic                          ctrl_we,
   input  logic [7:0]                    ctrl_wdata,
   input  logic                          cmd_we,
   input  logic [CMD_IDX_W-1:0]          cmd_idx,
   input  logic [7:0]                    cmd_wdata,
   input  logic                          imp_stb,
   output logic [(NF*(FW/8)+2)*8-1:0]    rx_bytes,
   output logic [7:0]                    ctrl_q,
   output logic [7:0]                    stat_lo,
   output logic                          act_valid,
   output logic [3:0]                    act_code,
   output logic                          irq4
);
   localparam int FB = FW / 8;
   localparam int AB = NF * FB + 2;
   localparam logic [7:0] CS_RST = 8'((1 << CSW) - 1);
   localparam logic [7:0] CTRL_KEEP = 8'h03;

   if (FW % 8 != 0 || FW < 16) begin : g_bad_fw
      $error("FW must be a multiple of 8 and at least 16");
   end
   if (CSW < 1 || CSW > 8) begin : g_bad_csw
      $error("CSW must lie in 1..8");
   end
   if ((1 << CMD_IDX_W) < AB) begin : g_bad_idx
      $error("CMD_IDX_W too small for the command area");
   end
   if (TOC_IDX >= AB || TOC_IDX < 1) begin : g_bad_toc
      $error("TOC_IDX outside the command area");
   end

   logic [FW-1:0]         stat_q;
   logic [AB-1:0][7:0]    rx_q, rx_d, cmd_q;
   logic [NF*FW-1:0]      fld_flat;
   logic [CSW-1:0]        csum;
   act_e                  dec_act, act_q;
   logic                  dec_upd;
   logic [7:0]            dec_lo;
   logic                  act_v_q, irq_q;
   logic [7:0]            ctrl_r;

   // field 0 is the status word, then minute, second, frame
   assign fld_flat = {frm_i, sec_i, min_i, stat_q};

   cdd_csum #(.FW(FW), .NF(NF), .EW(8), .CSW(CSW)) i_csum (
      .fields (fld_flat),
      .ext    (ext_i),
      .csum   (csum)
   );

   cdd_cmd_decode #(.NUM_SUB(NUM_SUB)) i_dec (
      .code_byte (cmd_q[0]),
      .sub_byte  (cmd_q[TOC_IDX]),
      .act       (dec_act),
      .lo_upd    (dec_upd),
      .lo_val    (dec_lo)
   );

   // packing: each field high byte first
   for (genvar gf = 0; gf < NF; gf++) begin : g_fld
      for (genvar gb = 0; gb < FB; gb++) begin : g_byte
         assign rx_d[gf*FB + gb] = fld_flat[gf*FW + FW - 1 - 8*gb -: 8];
      end
   end
   assign rx_d[AB-2] = ext_i;
   assign rx_d[AB-1] = {{(8-CSW){1'b0}}, csum};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_q         <= '0;
         rx_q[AB-1]   <= CS_RST;
         cmd_q        <= '0;
         stat_q       <= '0;
         ctrl_r       <= '0;
         act_v_q      <= 1'b0;
         act_q        <= ACT_STATUS;
         irq_q        <= 1'b0;
      end else begin
         if (exp_stb) begin
            rx_q <= rx_d;
         end
         if (cmd_we && 32'(cmd_idx) < AB) begin
            cmd_q[cmd_idx] <= cmd_wdata;
         end
         if (stat_we) begin
            stat_q <= stat_wdata;
         end
         if (imp_stb && dec_upd) begin
            stat_q[7:0] <= dec_lo;
         end
         ctrl_r  <= (ctrl_we ? ctrl_wdata : ctrl_r) & (exp_stb ? CTRL_KEEP : 8'hFF);
         act_v_q <= imp_stb;
         if (imp_stb) begin
            act_q <= dec_act;
         end
         irq_q   <= exp_stb & irq_en;
      end
   end

   assign rx_bytes  = rx_q;
   assign ctrl_q    = ctrl_r;
   assign stat_lo   = stat_q[7:0];
   assign act_valid = act_v_q;
   assign act_code  = act_q;
   assign irq4      = irq_q;

   AST_ACT_AFTER_IMPORT: assert property (@(posedge clk) disable iff (!rst_n)
      imp_stb |=> act_valid) else $error("action valid missing");  // R8
   AST_NO_SPURIOUS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      !imp_stb |=> !act_valid) else $error("spurious action valid");  // R8
   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> (act_code != 4'h5 && act_code != 4'hB && act_code != 4'hE))
      else $error("illegal action code");  // R6
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq4 |-> $past(exp_stb && irq_en)) else $error("irq without export");  // R5
   AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      exp_stb |=> ctrl_q[7:2] == 6'd0) else $error("control not masked");  // R4
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !exp_stb |=> $stable(rx_bytes)) else $error("receive area moved");  // R10
   AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_we && !imp_stb) |=> $stable(stat_lo)) else $error("status moved");  // R7

endmodule

// File: tb/test_cdd_pkt_unit.sv
module test_cdd_pkt_unit;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        stat_we;
   logic [15:0] stat_wdata, min_i, sec_i, frm_i;
   logic [7:0]  ext_i;
   logic        irq_en, exp_stb, ctrl_we, cmd_we, imp_stb;
   logic [7:0]  ctrl_wdata, cmd_wdata;
   logic [3:0]  cmd_idx;
   logic [79:0] rx_bytes;
   logic [7:0]  ctrl_q, stat_lo;
   logic        act_valid, irq4;
   logic [3:0]  act_code;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   logic [15:0] m_stat;
   logic [7:0]  m_ctrl;
   logic [7:0]  m_cmd [10];
   logic [79:0] m_rx;

   always #(CLK_P/2) clk = ~clk;

   cdd_pkt_unit i_cdd_pkt_unit (
      .clk, .rst_n, .stat_we, .stat_wdata, .min_i, .sec_i, .frm_i, .ext_i,
      .irq_en, .exp_stb, .ctrl_we, .ctrl_wdata, .cmd_we, .cmd_idx, .cmd_wdata,
      .imp_stb, .rx_bytes, .ctrl_q, .stat_lo, .act_valid, .act_code, .irq4
   );

   function automatic logic [3:0] f_csum(logic [15:0] s, m, se, f, logic [7:0] e);
      logic [31:0] t;
      t = 32'(s) + 32'(s >> 8) + 32'(m) + 32'(m >> 8) + 32'(se) + 32'(se >> 8)
        + 32'(f) + 32'(f >> 8) + 32'(e);
      return ~t[3:0];
   endfunction

   function automatic logic [79:0] f_pack(logic [15:0] s, m, se, f, logic [7:0] e);
      logic [79:0] r;
      r[7:0]   = s[15:8];  r[15:8]  = s[7:0];
      r[23:16] = m[15:8];  r[31:24] = m[7:0];
      r[39:32] = se[15:8]; r[47:40] = se[7:0];
      r[55:48] = f[15:8];  r[63:56] = f[7:0];
      r[71:64] = e;
      r[79:72] = {4'h0, f_csum(s, m, se, f, e)};
      return r;
   endfunction

   function automatic logic [3:0] f_act(logic [7:0] code, logic [7:0] sub);
      case (code[3:0])
         4'h2: return (sub < 8'd6) ? 4'h2 : 4'h0;
         4'h5, 4'hB, 4'hE, 4'hF: return 4'hF;
         default: return code[3:0];
      endcase
   endfunction

   task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_cmd(int idx, logic [7:0] d);
      cmd_we = 1'b1; cmd_idx = 4'(idx); cmd_wdata = d;
      cyc();
      cmd_we = 1'b0;
      if (idx < 10) m_cmd[idx] = d;
      chk("R8 no valid without import", 80'(act_valid), 80'(0));
   endtask

   // one cycle with the given strobes; field inputs already set
   task automatic op(bit e, bit i, bit sw, bit cw, string tag);
      logic [3:0]  x_act;
      logic [15:0] x_stat;
      logic [7:0]  x_ctrl;
      logic [79:0] x_rx;
      logic        x_irq;
      x_act  = f_act(m_cmd[0], m_cmd[3]);
      x_rx   = e ? f_pack(m_stat, min_i, sec_i, frm_i, ext_i) : m_rx;
      x_stat = sw ? stat_wdata : m_stat;
      if (i && m_cmd[0][3:0] == 4'h2)
         x_stat[7:0] = (m_cmd[3] < 8'd6) ? m_cmd[3] : 8'h0F;
      x_ctrl = cw ? ctrl_wdata : m_ctrl;
      if (e) x_ctrl = x_ctrl & 8'h03;
      x_irq  = e & irq_en;
      exp_stb = e; imp_stb = i; stat_we = sw; ctrl_we = cw;
      cyc();
      exp_stb = 0; imp_stb = 0; stat_we = 0; ctrl_we = 0;
      m_stat = x_stat; m_ctrl = x_ctrl; m_rx = x_rx;
      chk({tag, " R2 R3 R9 R10 rx"}, rx_bytes, x_rx);
      chk({tag, " R7 R11 stat_lo"}, 80'(stat_lo), 80'(x_stat[7:0]));
      chk({tag, " R4 ctrl"}, 80'(ctrl_q), 80'(x_ctrl));
      chk({tag, " R5 irq4"}, 80'(irq4), 80'(x_irq));
      chk({tag, " R8 act_valid"}, 80'(act_valid), 80'(i));
      if (i) chk({tag, " R6 R7 act_code"}, 80'(act_code), 80'(x_act));
      if (e || i) begin
         cyc();
         chk({tag, " R5 R8 pulses end"}, 80'({act_valid, irq4}), 80'(0));
      end
   endtask

   task automatic export_stat(string tag);
      // second export reveals the full status word (high byte included)
      op(1, 0, 0, 0, tag);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      rst_n = 0; stat_we = 0; stat_wdata = 0; min_i = 0; sec_i = 0; frm_i = 0;
      ext_i = 0; irq_en = 0; exp_stb = 0; ctrl_we = 0; ctrl_wdata = 0;
      cmd_we = 0; cmd_idx = 0; cmd_wdata = 0; imp_stb = 0;
      repeat (3) cyc();
      rst_n = 1;
      #1;
      m_stat = 0; m_ctrl = 0; m_rx = 80'h0F << 72;
      foreach (m_cmd[k]) m_cmd[k] = 0;
      chk("R1 rx reset", rx_bytes, 80'h0F << 72);
      chk("R1 ctrl/stat reset", 80'({ctrl_q, stat_lo}), 80'(0));
      chk("R1 pulses reset", 80'({act_valid, irq4}), 80'(0));

      // all-zero export keeps checksum 0xF
      op(1, 0, 0, 0, "zero-export");

      // directed export with known values, irq enabled, control write masked
      stat_wdata = 16'h1234;
      op(0, 0, 1, 0, "stat-load");
      min_i = 16'h0002; sec_i = 16'h0059; frm_i = 16'h0074; ext_i = 8'h05;
      irq_en = 1; ctrl_wdata = 8'hFF;
      op(1, 0, 0, 1, "R2 directed");
      irq_en = 0;
      op(1, 0, 0, 0, "R5 irq masked");

      // TOC valid sub 5, then invalid sub 6, upper nibble of byte 0 ignored
      wr_cmd(0, 8'hA2); wr_cmd(3, 8'h05);
      op(0, 1, 0, 0, "R7 toc sub5");
      wr_cmd(3, 8'h06);
      op(0, 1, 0, 0, "R7 toc bad sub");
      export_stat("R7 high byte kept");
      // unused codes map to default
      wr_cmd(0, 8'h05);
      op(0, 1, 0, 0, "R6 code5");
      wr_cmd(0, 8'h3E);
      op(0, 1, 0, 0, "R6 codeE");
      // out-of-range index ignored
      wr_cmd(12, 8'h01);
      op(0, 1, 0, 0, "R11 idx12 ignored");

      // export and import together with a TOC command, plus status write
      wr_cmd(0, 8'h02); wr_cmd(3, 8'h01);
      stat_wdata = 16'hBEEF;
      op(1, 1, 1, 0, "R9 R11 same cycle");
      export_stat("R11 high byte from write");

      for (int n = 0; n < 400; n++) begin
         int sel;
         sel = $urandom % 4;
         if (sel == 0) wr_cmd(0, 8'($urandom));
         if (sel == 1) wr_cmd(3, ($urandom % 2) ? 8'($urandom % 8) : 8'($urandom));
         if (sel == 2) wr_cmd($urandom % 16, 8'($urandom));
         min_i = 16'($urandom); sec_i = 16'($urandom); frm_i = 16'($urandom);
         ext_i = 8'($urandom); stat_wdata = 16'($urandom);
         ctrl_wdata = 8'($urandom); irq_en = 1'($urandom);
         op(1'($urandom), ($urandom % 3) == 0, ($urandom % 4) == 0,
            ($urandom % 4) == 0, "rand");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule